// File: doc/BRIEF.md
# Iterative Tweakable Wide-Block Cipher Core

This core encrypts or decrypts one 256-bit block under a 128-bit tweak. It runs one cipher step per clock. The block is held as four 32-bit x words and four 32-bit y words. Each step pairs one x word with one y word into a branch. It XORs in that step's subkeys and passes each branch through an add-rotate-xor box with a per-branch constant. It then mixes the branches through a 16-bit-shift linear map and rotates the branch order. On odd steps the tweak is XORed into the first two branches before the subkeys. Seventeen such steps are followed by a final subkey XOR over all eight words.

The key schedule lives outside the core. The core requests subkey sets by index through a valid/valid fetch: it raises `sk_req` with `sk_step`, and an external store answers with `sk_vld` and all eight words of that set on `sk_data`. The store may stall, and the core waits without losing state. A single `start` pulse with the `decrypt` bit selects the direction. `busy` covers the run, and `done` pulses once when the result sits on `x_out`/`y_out`. Decryption undoes every operation of encryption, in reverse order.

Top module: `tbc_step_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `sk_req` are low and `x_out`/`y_out` are zero.
- R2: Encryption yields the cipher output. Word i of `x_in`, `y_in`, `x_out` and `y_out` sits at bits 32i+31:32i. Tweak word j sits at `tweak_in` bits 32j+31:32j. On odd steps, tweak words 0,1,2,3 go into x0,y0,x1,y1.
- R3: An encryption fetches subkey sets in index order 0,1,...,17, one index per accepted fetch. Set word 2b is XORed into x[b] and word 2b+1 into y[b], where word k of `sk_data` is bits 32k+31:32k.
- R4: Decryption fetches indices 17,16,...,0. It returns the original block when given an encryption result under the same subkeys and tweak.
- R5: With `sk_vld` held high, `done` is high exactly 18 cycles after the cycle in which `start` is sampled. `done` lasts one cycle, and `busy` is low while `done` is high.
- R6: Once idle, `x_out`/`y_out` hold their value until the next accepted `start`, whatever the other inputs do.
- R7: `start` is ignored while `busy` is high, including in the cycle of the final fetch. A `start` in the `done` cycle is accepted.
- R8: A cycle with `busy` high and `sk_vld` low changes neither the state nor `sk_step`, and the run still completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| decrypt | input | 1 | 1 selects decryption, sampled with start |
| x_in | input | 128 | Input x words |
| y_in | input | 128 | Input y words |
| tweak_in | input | 128 | Tweak, sampled with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | 128 | Result x words |
| y_out | output | 128 | Result y words |
| sk_req | output | 1 | Subkey set requested |
| sk_step | output | 5 | Index of the requested subkey set |
| sk_vld | input | 1 | Subkey set valid on sk_data |
| sk_data | input | 256 | Eight 32-bit subkey words |

## Verification
Two events can coincide in one cycle: a new `start` and the final subkey fetch, and a new `start` and the `done` pulse. The bench raises `start` with different data in the last busy cycle and at a mid-run cycle. It judges that the result still matches the first operation and that the fetch order is unbroken. It then issues `start` in the very cycle `done` shows. That second operation must run fully, with correct indices and output. Random stalls on `sk_vld` are mixed in so that stall cycles also fall on these boundaries.

// File: rtl/tbc_pkg.sv
// Shared types and helpers for the tweakable wide-block cipher core.
// Assumes a 32-bit word; rotation amounts are fixed by the cipher.
package tbc_pkg;
    localparam int W     = 32;
    localparam int NBR   = 4;
    localparam int NSTEP = 17;
    localparam int SKW   = $clog2(NSTEP + 2);

    typedef logic [W-1:0]           word_t;
    typedef logic [NBR-1:0][W-1:0]  half_t;

    // Right rotation of a word.
    function automatic word_t rotr(word_t v, int n);
        return (v >> n) | (v << (W - n));
    endfunction

    // Linear map: rotate right by half a word after folding the low half up.
    function automatic word_t ellmix(word_t v);
        return rotr(v ^ (v << (W / 2)), W / 2);
    endfunction

    // Eight round constants, selected by a 3-bit index.
    function automatic word_t rcon(logic [2:0] i);
        case (i)
            3'd0: return 32'hB7E15162;
            3'd1: return 32'hBF715880;
            3'd2: return 32'h38B4DA56;
            3'd3: return 32'h324E7738;
            3'd4: return 32'hBB1185EB;
            3'd5: return 32'h4F7C7B57;
            3'd6: return 32'hCFBFA1C8;
            default: return 32'hC2B3293D;
        endcase
    endfunction
endpackage

// File: rtl/tbc_arx.sv
// Add-rotate-xor box on one branch (x,y) with constant c.
// INVERSE=0 gives the forward box, INVERSE=1 its exact inverse. Purely combinational.
module tbc_arx
    import tbc_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  word_t x_i,
    input  word_t y_i,
    input  word_t c_i,
    output word_t x_o,
    output word_t y_o
);
    // Four add/xor rounds, run forward or undone backward.
    always_comb begin
        word_t a, b;
        a = x_i;
        b = y_i;
        if (!INVERSE) begin
            a = a + rotr(b, 31); b = b ^ rotr(a, 24); a = a ^ c_i;
            a = a + rotr(b, 17); b = b ^ rotr(a, 17); a = a ^ c_i;
            a = a + b;           b = b ^ rotr(a, 31); a = a ^ c_i;
            a = a + rotr(b, 24); b = b ^ rotr(a, 16); a = a ^ c_i;
        end else begin
            a = a ^ c_i; b = b ^ rotr(a, 16); a = a - rotr(b, 24);
            a = a ^ c_i; b = b ^ rotr(a, 31); a = a - b;
            a = a ^ c_i; b = b ^ rotr(a, 17); a = a - rotr(b, 17);
            a = a ^ c_i; b = b ^ rotr(a, 24); a = a - rotr(b, 31);
        end
        x_o = a;
        y_o = b;
    end
endmodule

// File: rtl/tbc_mix.sv
// Branch-mixing linear layer plus branch rotation.
// Forward: mix then rotate (new 0,1,2,3 <- old 3,2,0,1). Inverse: unrotate then mix.
// The two mix halves touch disjoint words, so their order does not matter.
module tbc_mix
    import tbc_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  half_t x_i,
    input  half_t y_i,
    output half_t x_o,
    output half_t y_o
);
    // Feistel-like mix of the upper branches into the lower, with rotation.
    always_comb begin
        half_t px, py;
        word_t tm, um;
        if (INVERSE) begin
            px[0] = x_i[2]; px[1] = x_i[3]; px[2] = x_i[1]; px[3] = x_i[0];
            py[0] = y_i[2]; py[1] = y_i[3]; py[2] = y_i[1]; py[3] = y_i[0];
        end else begin
            px = x_i;
            py = y_i;
        end
        tm = ellmix(px[2] ^ px[3]);
        um = ellmix(py[2] ^ py[3]);
        py[0] = py[0] ^ tm; py[1] = py[1] ^ tm;
        px[0] = px[0] ^ um; px[1] = px[1] ^ um;
        if (INVERSE) begin
            x_o = px;
            y_o = py;
        end else begin
            x_o[0] = px[3]; x_o[1] = px[2]; x_o[2] = px[0]; x_o[3] = px[1];
            y_o[0] = py[3]; y_o[1] = py[2]; y_o[2] = py[0]; y_o[3] = py[1];
        end
    end
endmodule

// File: rtl/tbc_step_core.sv
// Iterative tweakable wide-block cipher core: one step per accepted subkey fetch.
// Assumes the subkey store answers sk_step with the matching set while sk_vld is high.
// Encrypt visits sets 0..NSTEP (last is the final XOR); decrypt visits NSTEP..0.
module tbc_step_core
    import tbc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  decrypt,
    input  logic [NBR*W-1:0]      x_in,
    input  logic [NBR*W-1:0]      y_in,
    input  logic [NBR*W-1:0]      tweak_in,
    output logic                  busy,
    output logic                  done,
    output logic [NBR*W-1:0]      x_out,
    output logic [NBR*W-1:0]      y_out,
    output logic                  sk_req,
    output logic [SKW-1:0]        sk_step,
    input  logic                  sk_vld,
    input  logic [2*NBR*W-1:0]    sk_data
);
    localparam logic [SKW-1:0] LAST = SKW'(NSTEP);

    half_t xs, ys, tw_r;
    logic  dec_r;
    logic [SKW-1:0] ph;

    logic  odd, fin;
    half_t skx, sky, twx, twy;
    half_t ex_a, ey_a, ex_f, ey_f, ex_n, ey_n;
    half_t dx_m, dy_m, dx_i, dy_i, dx_n, dy_n;
    half_t nx, ny;
    word_t rc [NBR];

    assign sk_step = dec_r ? (LAST - ph) : ph;
    assign odd     = sk_step[0];
    assign fin     = dec_r ? (ph == '0) : (ph == LAST);
    assign sk_req  = busy;
    assign x_out   = xs;
    assign y_out   = ys;

    // Split the fetched set into per-branch x and y subkeys and gate the tweak.
    always_comb begin
        twx = '0;
        twy = '0;
        for (int b = 0; b < NBR; b++) begin
            skx[b] = sk_data[(2*b)*W +: W];
            sky[b] = sk_data[(2*b+1)*W +: W];
        end
        if (odd) begin
            twx[0] = tw_r[0]; twy[0] = tw_r[1];
            twx[1] = tw_r[2]; twy[1] = tw_r[3];
        end
    end

    assign ex_a = xs ^ twx ^ skx;
    assign ey_a = ys ^ twy ^ sky;

    // Per-branch constants and the forward/inverse boxes for each branch.
    for (genvar b = 0; b < NBR; b++) begin : g_br
        assign rc[b] = rcon(3'(b) ^ {odd, 2'b00});
        tbc_arx #(.INVERSE(1'b0)) u_fwd (
            .x_i(ex_a[b]), .y_i(ey_a[b]), .c_i(rc[b]),
            .x_o(ex_f[b]), .y_o(ey_f[b])
        );
        tbc_arx #(.INVERSE(1'b1)) u_inv (
            .x_i(dx_m[b]), .y_i(dy_m[b]), .c_i(rc[b]),
            .x_o(dx_i[b]), .y_o(dy_i[b])
        );
    end

    tbc_mix #(.INVERSE(1'b0)) u_mix_fwd (
        .x_i(ex_f), .y_i(ey_f), .x_o(ex_n), .y_o(ey_n)
    );
    tbc_mix #(.INVERSE(1'b1)) u_mix_inv (
        .x_i(xs), .y_i(ys), .x_o(dx_m), .y_o(dy_m)
    );

    assign dx_n = dx_i ^ skx ^ twx;
    assign dy_n = dy_i ^ sky ^ twy;

    // Choose the next state: final XOR, inverse step or forward step.
    always_comb begin
        if (fin) begin
            nx = xs ^ skx;
            ny = ys ^ sky;
        end else if (dec_r) begin
            nx = dx_n;
            ny = dy_n;
        end else begin
            nx = ex_n;
            ny = ey_n;
        end
    end

    // Control and state registers: load on start, advance on each accepted fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xs    <= '0;
            ys    <= '0;
            tw_r  <= '0;
            dec_r <= 1'b0;
            ph    <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    xs    <= x_in;
                    ys    <= y_in;
                    tw_r  <= tweak_in;
                    dec_r <= decrypt;
                    ph    <= '0;
                    busy  <= 1'b1;
                end
            end else if (sk_vld) begin
                xs <= nx;
                ys <= ny;
                ph <= ph + 1'b1;
                if (ph == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tbc_step_core_chk.sv
// Property checker for tbc_step_core, attached by bind below.
// Observes ports only; assumes the synchronous active-low reset of the core.
module tbc_step_core_chk
    import tbc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [NBR*W-1:0]   x_out,
    input logic [NBR*W-1:0]   y_out,
    input logic               sk_req,
    input logic [SKW-1:0]     sk_step,
    input logic               sk_vld
);
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(x_out) && $stable(y_out)));

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sk_vld) |=> (busy && $stable(sk_step) && $stable(x_out) && $stable(y_out)));

    a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        sk_req |-> (sk_step <= SKW'(NSTEP)));

    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !sk_vld) |=> busy);
endmodule

bind tbc_step_core tbc_step_core_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .x_out(x_out), .y_out(y_out), .sk_req(sk_req), .sk_step(sk_step),
    .sk_vld(sk_vld)
);

// File: tb/tbc_step_core_tb_top.sv
// Self-checking bench: random keys, blocks and tweaks plus directed corners,
// compared with a software model of the cipher written here.
module tbc_step_core_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, decrypt = 1'b0;
    logic [127:0] x_in = '0, y_in = '0, tweak_in = '0;
    logic busy, done, sk_req, sk_vld = 1'b0;
    logic [127:0] x_out, y_out;
    logic [4:0] sk_step;
    logic [255:0] sk_data = '0;

    logic [255:0] sk_tab [0:17];
    int total = 0, bad = 0;
    int exp_idx = 0, nfetch = 0, order_bad = 0;
    bit dir_dec = 0, stall_en = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    tbc_step_core dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
        .x_in(x_in), .y_in(y_in), .tweak_in(tweak_in),
        .busy(busy), .done(done), .x_out(x_out), .y_out(y_out),
        .sk_req(sk_req), .sk_step(sk_step), .sk_vld(sk_vld), .sk_data(sk_data)
    );

    task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(0, "watchdog", 256'(cycles), 256'd150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Subkey store with optional stalls, and fetch order logging.
    always @(negedge clk) begin
        sk_vld  = stall_en ? (($urandom % 4) != 0) : 1'b1;
        sk_data = sk_tab[(sk_step <= 5'd17) ? sk_step : 5'd0];
        if (sk_req && sk_vld) begin
            if (int'(sk_step) != exp_idx) order_bad++;
            nfetch++;
            exp_idx = dir_dec ? exp_idx - 1 : exp_idx + 1;
        end
    end

    function automatic logic [31:0] m_rot(input logic [31:0] v, input int n);
        return (v >> n) | (v << (32 - n));
    endfunction

    function automatic logic [31:0] m_ell(input logic [31:0] v);
        return m_rot(v ^ (v << 16), 16);
    endfunction

    function automatic logic [31:0] m_rc(input int i);
        case (i % 8)
            0: return 32'hB7E15162; 1: return 32'hBF715880;
            2: return 32'h38B4DA56; 3: return 32'h324E7738;
            4: return 32'hBB1185EB; 5: return 32'h4F7C7B57;
            6: return 32'hCFBFA1C8; default: return 32'hC2B3293D;
        endcase
    endfunction

    task automatic m_box(inout logic [31:0] x, inout logic [31:0] y, input logic [31:0] c, input bit inv);
        if (!inv) begin
            x += m_rot(y, 31); y ^= m_rot(x, 24); x ^= c;
            x += m_rot(y, 17); y ^= m_rot(x, 17); x ^= c;
            x += y;            y ^= m_rot(x, 31); x ^= c;
            x += m_rot(y, 24); y ^= m_rot(x, 16); x ^= c;
        end else begin
            x ^= c; y ^= m_rot(x, 16); x -= m_rot(y, 24);
            x ^= c; y ^= m_rot(x, 31); x -= y;
            x ^= c; y ^= m_rot(x, 17); x -= m_rot(y, 17);
            x ^= c; y ^= m_rot(x, 24); x -= m_rot(y, 31);
        end
    endtask

    // Key schedule used only to fill the subkey store.
    task automatic fill_keys(input logic [255:0] key);
        logic [31:0] k [8];
        logic [31:0] t;
        for (int b = 0; b < 8; b++) k[b] = key[32*b +: 32];
        for (int s = 0; s < 18; s++) begin
            for (int b = 0; b < 8; b++) sk_tab[s][32*b +: 32] = k[b];
            k[0] += k[1] + m_rc(2*s);
            k[2] ^= k[3] ^ 32'(s);
            k[4] += k[5] + m_rc(2*s + 1);
            k[6] ^= k[7] ^ (32'(s) << 16);
            t = k[0];
            for (int b = 1; b < 8; b++) k[b-1] = k[b];
            k[7] = t;
        end
    endtask

    task automatic model(input bit dec, input logic [127:0] xi, input logic [127:0] yi,
                         input logic [127:0] tw, output logic [127:0] xo, output logic [127:0] yo);
        logic [31:0] x [4];
        logic [31:0] y [4];
        logic [31:0] tx, ty, a, b2;
        for (int b = 0; b < 4; b++) begin x[b] = xi[32*b +: 32]; y[b] = yi[32*b +: 32]; end
        if (!dec) begin
            for (int s = 0; s < 17; s++) begin
                if (s % 2 == 1) begin
                    x[0] ^= tw[31:0]; y[0] ^= tw[63:32]; x[1] ^= tw[95:64]; y[1] ^= tw[127:96];
                end
                for (int b = 0; b < 4; b++) begin
                    a  = x[b] ^ sk_tab[s][64*b +: 32];
                    b2 = y[b] ^ sk_tab[s][64*b+32 +: 32];
                    m_box(a, b2, m_rc(4*s + b), 0);
                    x[b] = a; y[b] = b2;
                end
                tx = m_ell(x[2] ^ x[3]); y[0] ^= tx; y[1] ^= tx;
                ty = m_ell(y[2] ^ y[3]); x[0] ^= ty; x[1] ^= ty;
                tx = x[0]; x[0] = x[3]; x[3] = x[1]; x[1] = x[2]; x[2] = tx;
                ty = y[0]; y[0] = y[3]; y[3] = y[1]; y[1] = y[2]; y[2] = ty;
            end
            for (int b = 0; b < 4; b++) begin
                x[b] ^= sk_tab[17][64*b +: 32]; y[b] ^= sk_tab[17][64*b+32 +: 32];
            end
        end else begin
            for (int b = 0; b < 4; b++) begin
                x[b] ^= sk_tab[17][64*b +: 32]; y[b] ^= sk_tab[17][64*b+32 +: 32];
            end
            for (int s = 16; s >= 0; s--) begin
                ty = y[0]; y[0] = y[2]; y[2] = y[1]; y[1] = y[3]; y[3] = ty;
                tx = x[0]; x[0] = x[2]; x[2] = x[1]; x[1] = x[3]; x[3] = tx;
                ty = m_ell(y[2] ^ y[3]); x[0] ^= ty; x[1] ^= ty;
                tx = m_ell(x[2] ^ x[3]); y[0] ^= tx; y[1] ^= tx;
                for (int b = 0; b < 4; b++) begin
                    a = x[b]; b2 = y[b];
                    m_box(a, b2, m_rc(4*s + b), 1);
                    x[b] = a ^ sk_tab[s][64*b +: 32];
                    y[b] = b2 ^ sk_tab[s][64*b+32 +: 32];
                end
                if (s % 2 == 1) begin
                    x[0] ^= tw[31:0]; y[0] ^= tw[63:32]; x[1] ^= tw[95:64]; y[1] ^= tw[127:96];
                end
            end
        end
        for (int b = 0; b < 4; b++) begin xo[32*b +: 32] = x[b]; yo[32*b +: 32] = y[b]; end
    endtask

    // Drive start at the current falling edge, optionally poke start mid-run, wait for done.
    task automatic run_op(input bit dec, input logic [127:0] xi, input logic [127:0] yi,
                          input logic [127:0] tw, input int poke,
                          output logic [127:0] xo, output logic [127:0] yo, output int cyc);
        decrypt = dec; x_in = xi; y_in = yi; tweak_in = tw; start = 1'b1;
        dir_dec = dec; exp_idx = dec ? 17 : 0; nfetch = 0; order_bad = 0;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (cyc == poke) begin
                start = 1'b1; x_in = ~xi; y_in = ~yi; tweak_in = ~tw; decrypt = ~dec;
            end
        end while (!done && cyc < 2000);
        xo = x_out; yo = y_out;
    endtask

    // One encrypt/decrypt pair against the model with order, latency and round-trip checks.
    task automatic pair(input logic [127:0] xi, input logic [127:0] yi, input logic [127:0] tw,
                        input int poke, input string tag);
        logic [127:0] cx, cy, ex, ey, px, py;
        int cyc;
        run_op(0, xi, yi, tw, poke, cx, cy, cyc);
        model(0, xi, yi, tw, ex, ey);
        check({cx, cy} == {ex, ey}, {"R2 enc ", tag}, {cx, cy}, {ex, ey});
        check(order_bad == 0 && nfetch == 18, {"R3 enc order ", tag}, 256'(nfetch), 256'd18);
        if (!stall_en) check(cyc == 19, {"R5 latency ", tag}, 256'(cyc), 256'd19);
        check(!busy, {"R5 busy low at done ", tag}, 256'(busy), 256'd0);
        @(negedge clk);
        check(!done, {"R5 done one cycle ", tag}, 256'(done), 256'd0);
        run_op(1, cx, cy, tw, poke, px, py, cyc);
        model(1, cx, cy, tw, ex, ey);
        check({px, py} == {ex, ey}, {"R4 dec model ", tag}, {px, py}, {ex, ey});
        check({px, py} == {xi, yi}, {"R4 round trip ", tag}, {px, py}, {xi, yi});
        check(order_bad == 0 && nfetch == 18, {"R4 dec order ", tag}, 256'(nfetch), 256'd18);
        @(negedge clk);
    endtask

    initial begin
        logic [127:0] hx, hy, ex, ey, cx, cy;
        int cyc;
        void'($urandom(32'h5EED_0042));
        fill_keys('0);
        repeat (3) @(negedge clk);
        check(!busy && !done && !sk_req && x_out == '0 && y_out == '0, "R1 in reset",
              {busy, done, sk_req, x_out[0]}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !sk_req && {x_out, y_out} == '0, "R1 after reset",
              {x_out, y_out}, '0);

        // Directed: all zero, all ones.
        pair('0, '0, '0, 0, "zero");
        fill_keys({8{32'hFFFFFFFF}});
        pair({4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, 0, "ones");

        // Random keys, blocks, tweaks.
        for (int i = 0; i < 12; i++) begin
            fill_keys({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
            pair({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, 0, "rand");
        end

        // R7: start while busy, mid-run and in the final fetch cycle.
        pair({4{$urandom}}, {4{$urandom}}, {4{$urandom}}, 5, "R7 mid poke");
        pair({4{$urandom}}, {4{$urandom}}, {4{$urandom}}, 18, "R7 last poke");

        // R8: random stalls on the subkey store.
        stall_en = 1;
        for (int i = 0; i < 5; i++) begin
            fill_keys({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
            pair({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, 0, "R8 stall");
        end
        stall_en = 0;

        // R7: back-to-back, second start in the done cycle.
        hx = {$urandom, $urandom, $urandom, $urandom};
        hy = {$urandom, $urandom, $urandom, $urandom};
        run_op(0, hx, hy, 128'h1234, 0, cx, cy, cyc);
        run_op(0, cx, cy, 128'h1234, 0, ex, ey, cyc);
        check(order_bad == 0 && nfetch == 18 && cyc == 19, "R7 start in done cycle",
              256'(cyc), 256'd19);
        model(0, hx, hy, 128'h1234, hx, hy);
        model(0, hx, hy, 128'h1234, hx, hy);
        check({ex, ey} == {hx, hy}, "R7 back-to-back result", {ex, ey}, {hx, hy});

        // R6: result held while inputs wander and start stays low.
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            x_in = {4{$urandom}}; y_in = {4{$urandom}}; tweak_in = {4{$urandom}};
            decrypt = 1'($urandom);
            @(negedge clk);
        end
        check({x_out, y_out} == {ex, ey}, "R6 output held", {x_out, y_out}, {ex, ey});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule